// File: doc/BRIEF.md
# Return Stack Sequencer

This block owns an 8-bit stack pointer that addresses a fixed stack page in a byte-wide memory. Single-byte pushes and pops arrive as valid/ready requests. Two start strobes launch multi-cycle return sequences. A plain return pulls a two-byte return address. A return-from-interrupt first pulls a saved status byte and then the same two-byte address. The stack grows downward, and callers push the high address byte before the low one. The low byte of the return address therefore sits at the lower memory location, and a return pops the low byte first.

The memory port answers a read one cycle after the read strobe, so every byte transfer spans two cycles: an address cycle and a data cycle. A push or pop is accepted only while the sequencer is idle. Its ready drops for the single recovery cycle after acceptance. The popped byte is presented with a one-cycle `pop_rvalid` pulse that has no back-pressure, so a consumer must take it in that cycle. `push_data` only needs to be stable while `push_valid` is high and `push_ready` answers. When several requests arrive in the same idle cycle, they are served in this order: return-from-interrupt, return, pop, push. Requests raised while the block is busy are ignored.

Top module: `rstk_sequencer`

## Requirements
- R1: After reset, SP equals the `SP_INIT` parameter (default 0xFF). `pc_out` and `psw_out` are zero, `busy` and `done` are low, and `push_ready` and `pop_ready` are high.
- R2: An accepted push drives `mem_wr` with `mem_addr` = {0x01, SP} and `mem_wdata` = `push_data` in the accepting cycle. SP then decrements by one, modulo 256 (0x00 becomes 0xFF).
- R3: An accepted pop drives `mem_rd` with `mem_addr` = {0x01, SP+1 mod 256} in the accepting cycle, and SP becomes that incremented value (0xFF becomes 0x00). In the following cycle `pop_rvalid` is high and `pop_rdata` carries the byte read.
- R4: Each push or pop occupies two cycles: both `push_ready` and `pop_ready` are low in the cycle after an acceptance.
- R5: After a return strobe, the block reads {0x01, SP+1} in cycle 1 and issues no access in cycle 2. It reads {0x01, SP+2} in cycle 3 and is busy in cycle 4. In cycle 5, `done` is high and `pc_out` = {byte at SP+2, byte at SP+1}.
- R6: After a return-from-interrupt strobe, the block reads SP+1 (status byte) in cycle 1 and SP+2 (address low) in cycle 2. It issues no access in cycle 3, reads SP+3 (address high) in cycle 4 and is busy in cycle 5. In cycle 6, `done` is high with `psw_out` and `pc_out` reloaded.
- R7: A plain return leaves `psw_out` unchanged.
- R8: Requests are ordered return-from-interrupt > return > pop > push in an idle cycle. Any strobe or request raised while `busy` is high causes no memory access and does not change SP.
- R9: `depth` always equals 0xFF minus SP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push request |
| push_ready | output | 1 | Push accepted when high together with push_valid |
| push_data | input | 8 | Byte to push |
| pop_valid | input | 1 | Pop request |
| pop_ready | output | 1 | Pop accepted when high together with pop_valid |
| pop_rvalid | output | 1 | Popped byte present this cycle |
| pop_rdata | output | 8 | Popped byte |
| ret_start | input | 1 | Start a plain return |
| reti_start | input | 1 | Start a return-from-interrupt |
| mem_addr | output | 16 | Memory byte address |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rd | output | 1 | Memory read strobe, data expected next cycle |
| mem_rdata | input | 8 | Memory read data |
| pc_out | output | 16 | Program counter |
| psw_out | output | 8 | Status word |
| done | output | 1 | Pulse: PC (and status) just reloaded |
| busy | output | 1 | A transfer or return sequence is in progress |
| sp_out | output | 8 | Stack pointer |
| depth | output | 8 | Bytes on the stack, 0xFF minus SP |

## Verification
Pushes and pops start from the reset pointer, so the pointer wraps in both directions right away. Return and return-from-interrupt sequences read back bytes that earlier pushes wrote. This separates a correct low/high byte order, and the status byte being taken before the address, from a swapped order. Cycle-by-cycle probes of the read strobe and address during each return confirm the idle gap and the total length. Stimulus that combines a return-from-interrupt strobe with a simultaneous return strobe, and raises push and return requests mid-sequence, confirms the priority and the ignoring of requests while busy. Seeded random mixes of all four operations cover arbitrary pointer positions.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_REC,
    ST_POP_WAIT,
    ST_RT_PSW,
    ST_RT_LO,
    ST_RT_GAP,
    ST_RT_HI,
    ST_RT_LOAD
  } seq_state_e;

  typedef enum logic [2:0] {
    TAG_NONE,
    TAG_POP,
    TAG_PSW,
    TAG_LO,
    TAG_HI
  } rd_tag_e;
endpackage

// File: rtl/rstk_sp_unit.sv
module rstk_sp_unit #(
  parameter int unsigned BYTE_W  = 8,
  parameter logic [BYTE_W-1:0] SP_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  output logic [BYTE_W-1:0] sp,
  output logic [BYTE_W-1:0] sp_up
);
  localparam logic [BYTE_W-1:0] ONE = BYTE_W'(1);

  logic [BYTE_W-1:0] sp_q;

  assign sp    = sp_q;
  assign sp_up = sp_q + ONE;

  always_ff @(posedge clk) begin
    if (!rst_n)   sp_q <= SP_INIT;
    else if (inc) sp_q <= sp_up;
    else if (dec) sp_q <= sp_q - ONE;
  end

  // R2: a push moves the pointer down by exactly one, wrapping
  p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc) |=> (sp_q == $past(sp_q) - ONE));

  // R3: a pop moves the pointer up by exactly one, wrapping
  p_pop_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (sp_q == $past(sp_q) + ONE));
endmodule

// File: rtl/rstk_seq.sv
module rstk_seq
  import rstk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push_valid,
  input  logic    pop_valid,
  input  logic    ret_start,
  input  logic    reti_start,
  output logic    push_ready,
  output logic    pop_ready,
  output logic    push_fire,
  output logic    rd_issue,
  output logic    busy,
  output rd_tag_e tag_q,
  output logic    is_reti
);
  seq_state_e state_q, state_d;
  rd_tag_e    tag_d;
  logic       idle, take_reti, take_ret, pop_fire, reti_q;

  assign idle      = (state_q == ST_IDLE);
  assign take_reti = idle && reti_start;
  assign take_ret  = idle && ret_start && !reti_start;
  assign pop_ready = idle && !ret_start && !reti_start;
  assign pop_fire  = pop_ready && pop_valid;
  assign push_ready = pop_ready && !pop_valid;
  assign push_fire = push_ready && push_valid;
  assign busy      = !idle;
  assign is_reti   = reti_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take_reti)      state_d = ST_RT_PSW;
        else if (take_ret)  state_d = ST_RT_LO;
        else if (pop_fire)  state_d = ST_POP_WAIT;
        else if (push_fire) state_d = ST_PUSH_REC;
      end
      ST_PUSH_REC: state_d = ST_IDLE;
      ST_POP_WAIT: state_d = ST_IDLE;
      ST_RT_PSW:   state_d = ST_RT_LO;
      ST_RT_LO:    state_d = ST_RT_GAP;
      ST_RT_GAP:   state_d = ST_RT_HI;
      ST_RT_HI:    state_d = ST_RT_LOAD;
      ST_RT_LOAD:  state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tag_d = TAG_NONE;
    if (pop_fire)                 tag_d = TAG_POP;
    else if (state_q == ST_RT_PSW) tag_d = TAG_PSW;
    else if (state_q == ST_RT_LO)  tag_d = TAG_LO;
    else if (state_q == ST_RT_HI)  tag_d = TAG_HI;
  end

  assign rd_issue = (tag_d != TAG_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tag_q   <= TAG_NONE;
      reti_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tag_q   <= tag_d;
      if (take_reti)     reti_q <= 1'b1;
      else if (take_ret) reti_q <= 1'b0;
    end
  end

  // R4: one recovery cycle after every single-byte transfer
  p_two_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire || pop_fire) |=> (!push_ready && !pop_ready));

  // R5: the low-byte read is followed by an access-free cycle
  p_ret_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RT_LO) |=> (state_q == ST_RT_GAP && !rd_issue));

  // R6: the status byte read comes right before the low-byte read
  p_reti_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RT_PSW) |=> (state_q == ST_RT_LO && rd_issue));

  // R8: nothing is accepted while a sequence runs
  p_busy_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!push_fire && !pop_ready));
endmodule

// File: rtl/rstk_assemble.sv
module rstk_assemble
  import rstk_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rd_tag_e             tag_q,
  input  logic                is_reti,
  input  logic [BYTE_W-1:0]   rdata,
  output logic [2*BYTE_W-1:0] pc,
  output logic [BYTE_W-1:0]   psw,
  output logic                done,
  output logic                pop_rvalid,
  output logic [BYTE_W-1:0]   pop_rdata
);
  logic [BYTE_W-1:0]   lo_q, psw_tmp_q, psw_q;
  logic [2*BYTE_W-1:0] pc_q;
  logic                done_q;

  assign pc         = pc_q;
  assign psw        = psw_q;
  assign done       = done_q;
  assign pop_rvalid = (tag_q == TAG_POP);
  assign pop_rdata  = rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q      <= '0;
      psw_tmp_q <= '0;
      psw_q     <= '0;
      pc_q      <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= (tag_q == TAG_HI);
      if (tag_q == TAG_PSW) psw_tmp_q <= rdata;
      if (tag_q == TAG_LO)  lo_q      <= rdata;
      if (tag_q == TAG_HI) begin
        pc_q <= {rdata, lo_q};
        if (is_reti) psw_q <= psw_tmp_q;
      end
    end
  end

  // R7: a plain return keeps the status word
  p_psw_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_q == TAG_HI && !is_reti) |=> $stable(psw_q));

  // R5: PC only moves when a reload is announced
  p_pc_moves_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(pc_q) || (tag_q == TAG_HI) || $past(tag_q == TAG_HI));
endmodule

// File: rtl/rstk_sequencer.sv
module rstk_sequencer #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter logic [ADDR_W-BYTE_W-1:0] STACK_PAGE = (ADDR_W-BYTE_W)'(1),
  parameter logic [BYTE_W-1:0] SP_INIT = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_valid,
  output logic                push_ready,
  input  logic [BYTE_W-1:0]   push_data,
  input  logic                pop_valid,
  output logic                pop_ready,
  output logic                pop_rvalid,
  output logic [BYTE_W-1:0]   pop_rdata,
  input  logic                ret_start,
  input  logic                reti_start,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_wr,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic                mem_rd,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [2*BYTE_W-1:0] pc_out,
  output logic [BYTE_W-1:0]   psw_out,
  output logic                done,
  output logic                busy,
  output logic [BYTE_W-1:0]   sp_out,
  output logic [BYTE_W-1:0]   depth
);
  import rstk_pkg::*;

  localparam logic [BYTE_W-1:0] SP_TOP = '1;

  logic             push_fire, rd_issue, is_reti;
  logic [BYTE_W-1:0] sp, sp_up;
  rd_tag_e          tag_q;

  rstk_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_valid  (pop_valid),
    .ret_start  (ret_start),
    .reti_start (reti_start),
    .push_ready (push_ready),
    .pop_ready  (pop_ready),
    .push_fire  (push_fire),
    .rd_issue   (rd_issue),
    .busy       (busy),
    .tag_q      (tag_q),
    .is_reti    (is_reti)
  );

  rstk_sp_unit #(.BYTE_W(BYTE_W), .SP_INIT(SP_INIT)) u_sp (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (rd_issue),
    .dec   (push_fire),
    .sp    (sp),
    .sp_up (sp_up)
  );

  rstk_assemble #(.BYTE_W(BYTE_W)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tag_q      (tag_q),
    .is_reti    (is_reti),
    .rdata      (mem_rdata),
    .pc         (pc_out),
    .psw        (psw_out),
    .done       (done),
    .pop_rvalid (pop_rvalid),
    .pop_rdata  (pop_rdata)
  );

  assign mem_rd    = rd_issue;
  assign mem_wr    = push_fire;
  assign mem_wdata = push_data;
  assign mem_addr  = {STACK_PAGE, (rd_issue ? sp_up : sp)};
  assign sp_out    = sp;
  assign depth     = SP_TOP - sp;

  // R2: writes never coincide with reads
  p_rw_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));

  // R6: a reload pulse never repeats on consecutive cycles
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/rstk_sequencer_tb.sv
`timescale 1ns/1ps
module rstk_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0, pop_valid = 1'b0;
  logic        ret_start = 1'b0, reti_start = 1'b0;
  logic [7:0]  push_data = '0;
  logic        push_ready, pop_ready, pop_rvalid, mem_wr, mem_rd, done, busy;
  logic [7:0]  pop_rdata, mem_wdata, psw_out, sp_out, depth;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, pc_out;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] ram [256];
  logic [7:0] shadow [256];
  logic [7:0] sp_m;
  logic [7:0] psw_m;

  always #5 clk = ~clk;

  rstk_sequencer u_dut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_rvalid(pop_rvalid), .pop_rdata(pop_rdata),
    .ret_start(ret_start), .reti_start(reti_start),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .pc_out(pc_out), .psw_out(psw_out), .done(done), .busy(busy),
    .sp_out(sp_out), .depth(depth)
  );

  always @(posedge clk) begin
    if (mem_wr) ram[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= ram[mem_addr[7:0]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stk(input logic [7:0] p);
    return {8'h01, p};
  endfunction

  task automatic do_push(input logic [7:0] d);
    @(negedge clk);
    push_valid = 1'b1; push_data = d;
    #1;
    chk("R2 ready", push_ready, 1);
    chk("R2 wr", mem_wr, 1);
    chk("R2 addr", mem_addr, stk(sp_m));
    chk("R2 wdata", mem_wdata, d);
    @(negedge clk);
    push_valid = 1'b0;
    shadow[sp_m] = d;
    sp_m = sp_m - 8'd1;
    chk("R2 sp", sp_out, sp_m);
    chk("R4 push busy", {push_ready, pop_ready}, 0);
    chk("R9 depth", depth, 8'hFF - sp_m);
  endtask

  task automatic do_pop();
    @(negedge clk);
    pop_valid = 1'b1;
    #1;
    chk("R3 ready", pop_ready, 1);
    chk("R3 rd", mem_rd, 1);
    chk("R3 addr", mem_addr, stk(sp_m + 8'd1));
    @(negedge clk);
    pop_valid = 1'b0;
    sp_m = sp_m + 8'd1;
    chk("R3 rvalid", pop_rvalid, 1);
    chk("R3 data", pop_rdata, shadow[sp_m]);
    chk("R3 sp", sp_out, sp_m);
    chk("R4 pop busy", {push_ready, pop_ready}, 0);
  endtask

  // use_reti: return-from-interrupt; both: raise plain return too;
  // inject: raise push and return requests mid-sequence
  task automatic do_ret(input bit use_reti, input bit both, input bit inject);
    int len;
    logic [15:0] exp_pc;
    logic [7:0]  exp_psw;
    len = use_reti ? 6 : 5;
    if (use_reti) begin
      exp_psw = shadow[sp_m + 8'd1];
      exp_pc  = {shadow[sp_m + 8'd3], shadow[sp_m + 8'd2]};
    end else begin
      exp_psw = psw_m;
      exp_pc  = {shadow[sp_m + 8'd2], shadow[sp_m + 8'd1]};
    end
    @(negedge clk);
    reti_start = use_reti;
    ret_start  = !use_reti || both;
    push_valid = inject;
    push_data  = 8'hA5;
    #1;
    chk("R8 push loses to return", push_ready, 0);
    chk("R8 no write at start", mem_wr, 0);
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      reti_start = 1'b0; ret_start = 1'b0; push_valid = 1'b0;
      if (inject && k == 2) begin
        push_valid = 1'b1; ret_start = 1'b1; reti_start = 1'b1;
        #1;
        chk("R8 busy no write", mem_wr, 0);
        chk("R8 busy no push", push_ready, 0);
      end
      if (use_reti) begin
        chk("R6 rd", mem_rd, (k == 1 || k == 2 || k == 4));
        if (k == 1) chk("R6 psw addr", mem_addr, stk(sp_m + 8'd1));
        if (k == 2) chk("R6 lo addr", mem_addr, stk(sp_m + 8'd2));
        if (k == 4) chk("R6 hi addr", mem_addr, stk(sp_m + 8'd3));
        chk("R6 done", done, (k == len));
        chk("R6 busy", busy, (k < len));
      end else begin
        chk("R5 rd", mem_rd, (k == 1 || k == 3));
        if (k == 1) chk("R5 lo addr", mem_addr, stk(sp_m + 8'd1));
        if (k == 3) chk("R5 hi addr", mem_addr, stk(sp_m + 8'd2));
        chk("R5 done", done, (k == len));
        chk("R5 busy", busy, (k < len));
      end
    end
    push_valid = 1'b0; ret_start = 1'b0; reti_start = 1'b0;
    sp_m = sp_m + (use_reti ? 8'd3 : 8'd2);
    chk(use_reti ? "R6 pc" : "R5 pc", pc_out, exp_pc);
    chk(use_reti ? "R6 psw" : "R7 psw kept", psw_out, exp_psw);
    chk("R8 sp after return", sp_out, sp_m);
    chk("R9 depth", depth, 8'hFF - sp_m);
    psw_m = exp_psw;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    int r;
    for (int i = 0; i < 256; i++) begin
      ram[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    sp_m = 8'hFF; psw_m = 8'h00;
    r = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sp", sp_out, 8'hFF);
    chk("R1 pc", pc_out, 0);
    chk("R1 psw", psw_out, 0);
    chk("R1 flags", {busy, done, push_ready, pop_ready}, 4'b0011);
    chk("R9 depth reset", depth, 8'h00);
    // R3 wrap 0xFF -> 0x00, R2 wrap 0x00 -> 0xFF
    do_pop();
    do_push(8'h3C);
    // call-style frame: high then low, then return
    do_push(8'h12); do_push(8'h34);
    do_ret(0, 0, 0);
    chk("R5 directed pc", pc_out, 16'h1234);
    // interrupt frame: pc high, pc low, status
    do_push(8'hBE); do_push(8'hEF); do_push(8'h5A);
    do_ret(1, 1, 1);
    chk("R6 directed pc", pc_out, 16'hBEEF);
    chk("R6 directed psw", psw_out, 8'h5A);
    do_push(8'h77); do_push(8'h88);
    do_ret(0, 0, 1);
    chk("R7 psw after ret", psw_out, 8'h5A);
    // R8 pop beats push in the same cycle
    @(negedge clk);
    pop_valid = 1'b1; push_valid = 1'b1;
    #1;
    chk("R8 pop over push", {pop_ready, push_ready, mem_rd, mem_wr}, 4'b1010);
    @(negedge clk);
    pop_valid = 1'b0; push_valid = 1'b0;
    sp_m = sp_m + 8'd1;
    chk("R8 pop data", pop_rdata, shadow[sp_m]);
    // random mix
    for (int n = 0; n < 400; n++) begin
      r = $urandom % 8;
      case (r)
        0, 1, 2: do_push(8'($urandom));
        3, 4:    do_pop();
        5:       do_ret(0, 0, 0);
        6:       do_ret(1, 0, 0);
        default: do_ret(1, 1, 1);
      endcase
    end
    finish_run();
  end
endmodule